// File: doc/BRIEF.md
# Banked RAM and ROM Overlay Mapper

This block turns a 16-bit processor address into a physical memory location. The processor space is cut into four 16 KB windows selected by address bits 15:14. Each window is backed by one of eight 16 KB RAM banks. A stored three-bit layout code picks which bank sits behind each window. Two overlay enables can place a lower ROM over window 0 and an upper ROM over window 3, but only for reads. Stores always land in the RAM bank mapped behind the window.

The layout code and the overlay enables are held in registers. Each is loaded by its own write strobe, so a new setting steers the first access after the clock edge that stores it. A parameter states whether the expanded RAM is fitted. When it is not, layout writes are discarded and the identity map stays in force. The ROM contents, the RAM arrays and the register that picks which upper ROM is fitted all live outside this block.

Top module: `bank_overlay_mapper`

## Requirements
- R1: `ram_addr[13:0]` equals `cpu_addr[13:0]`, and `ram_addr[16:14]` is the bank mapped to window `cpu_addr[15:14]`. This holds whatever the access type.
- R2: Layout codes map windows 0,1,2,3 to these banks: code 0 gives 0,1,2,3; code 1 gives 0,1,2,7; code 2 gives 4,5,6,7; code 3 gives 0,3,2,7; code 4 gives 0,4,2,3; code 5 gives 0,5,2,3; code 6 gives 0,6,2,3; code 7 gives 0,7,2,3.
- R3: After reset the layout code is 0 (identity map), and both the lower and the upper ROM overlays are enabled.
- R4: With `EXPANDED_RAM` = 0, writes of the layout code have no effect, and every window keeps the identity map.
- R5: A layout code presented with `map_we` high is stored at that clock edge. It steers outputs from the next cycle on. During the strobe cycle itself the old map still applies.
- R6: A read (`cpu_rd`=1, `cpu_wr`=0) of window 0 with the lower overlay enabled gives `rom_sel`=1, `rom_hi`=0, `ram_sel`=0 and `rom_offset`=`cpu_addr[13:0]`. With the lower overlay disabled, the same read gives `ram_sel`=1 and `rom_sel`=0.
- R7: A read of window 3 with the upper overlay enabled gives `rom_sel`=1, `rom_hi`=1 and `ram_sel`=0. With the upper overlay disabled, it gives `ram_sel`=1 and `rom_sel`=0.
- R8: Any access with `cpu_wr`=1 gives `ram_sel`=1 and `rom_sel`=0 in every window, whatever the overlay state and whatever `cpu_rd` is.
- R9: Reads of windows 1 and 2 always give `ram_sel`=1 and `rom_sel`=0.
- R10: With `cpu_rd`=0 and `cpu_wr`=0, both `ram_sel` and `rom_sel` are 0.
- R11: Overlay enables presented with `rom_we` high are stored at that clock edge, with `lo_rom_en`/`hi_rom_en` taking effect from the next cycle. An overlay write leaves the layout code unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| map_we | input | 1 | Store `map_code` at this edge |
| map_code | input | 3 | Bank layout code |
| rom_we | input | 1 | Store the overlay enables at this edge |
| lo_rom_en | input | 1 | Lower ROM overlay enable value |
| hi_rom_en | input | 1 | Upper ROM overlay enable value |
| cpu_addr | input | 16 | Processor address |
| cpu_rd | input | 1 | Read access |
| cpu_wr | input | 1 | Write access |
| ram_addr | output | 17 | Physical RAM address {bank, offset} |
| ram_sel | output | 1 | Access goes to RAM |
| rom_sel | output | 1 | Read served from a ROM overlay |
| rom_hi | output | 1 | 1 selects the upper ROM, 0 the lower |
| rom_offset | output | 14 | Byte offset inside the selected ROM |

## Verification
The checker watches every cycle for the following conditions:
- A store never reaches a ROM, and RAM and ROM are never selected together.
- Windows 1 and 2 never return ROM data.
- The RAM and ROM offsets follow the address.
- A build without expanded RAM never leaves the identity map.
- Window 0 and window 2 only ever use their two legal banks.

Some properties need a known history of writes, so only the bench scenarios can show them:
- The exact bank chosen for every code.
- The one-cycle delay between a strobe and its effect.
- That an overlay write leaves the layout untouched.
- The reset-time overlay state.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

   localparam int unsigned CODE_W  = 3;
   localparam int unsigned WIN_W   = 2;
   localparam int unsigned NUM_WIN = 1 << WIN_W;
   localparam int unsigned BANK_W  = 3;

   typedef logic [CODE_W-1:0] code_t;
   typedef logic [BANK_W-1:0] bank_t;
   typedef logic [WIN_W-1:0]  win_t;

   typedef struct packed {
      code_t code;
      logic  lo_en;
      logic  hi_en;
   } map_state_t;

   // Bank behind a window for a given layout code.
   function automatic bank_t layout_bank(input code_t code, input win_t win);
      bank_t b;
      case (win)
         2'd0: b = (code == 3'd2) ? 3'd4 : 3'd0;
         2'd1: begin
            if (code == 3'd2)      b = 3'd5;
            else if (code == 3'd3) b = 3'd3;
            else if (code[2])      b = code;
            else                   b = 3'd1;
         end
         2'd2: b = (code == 3'd2) ? 3'd6 : 3'd2;
         default: b = (code == 3'd1 || code == 3'd2 || code == 3'd3) ? 3'd7 : 3'd3;
      endcase
      return b;
   endfunction

   // Identity layout used when no expansion RAM exists.
   function automatic bank_t identity_bank(input win_t win);
      return bank_t'(win);
   endfunction

endpackage

// File: rtl/map_state_reg.sv
module map_state_reg
   import mapper_pkg::*;
#(
   parameter bit EXPANDED_RAM = 1'b1,
   parameter bit RST_LO_EN    = 1'b1,
   parameter bit RST_HI_EN    = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       map_we,
   input  code_t      map_code,
   input  logic       rom_we,
   input  logic       lo_rom_en,
   input  logic       hi_rom_en,
   output map_state_t state_q
);

   logic lo_q, hi_q;
   code_t code_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q <= RST_LO_EN;
         hi_q <= RST_HI_EN;
      end else if (rom_we) begin
         lo_q <= lo_rom_en;
         hi_q <= hi_rom_en;
      end
   end

   generate
      if (EXPANDED_RAM) begin : g_code_reg
         always_ff @(posedge clk) begin
            if (!rst_n)      code_q <= '0;
            else if (map_we) code_q <= map_code;
         end
      end else begin : g_code_fixed
         logic unused_map_in;
         assign unused_map_in = map_we ^ (^map_code) ^ clk;
         assign code_q = '0;
      end
   endgenerate

   assign state_q = '{code: code_q, lo_en: lo_q, hi_en: hi_q};

endmodule

// File: rtl/bank_table.sv
module bank_table
   import mapper_pkg::*;
#(
   parameter bit EXPANDED_RAM = 1'b1
) (
   input  code_t                     code,
   output logic [NUM_WIN-1:0][BANK_W-1:0] win_bank
);

   generate
      for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
         if (EXPANDED_RAM) begin : g_tab
            assign win_bank[w] = layout_bank(code, win_t'(w));
         end else begin : g_id
            assign win_bank[w] = identity_bank(win_t'(w));
         end
      end
      if (!EXPANDED_RAM) begin : g_unused
         logic unused_code;
         assign unused_code = ^code;
      end
   endgenerate

endmodule

// File: rtl/window_decode.sv
module window_decode
   import mapper_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   localparam int unsigned OFF_W = ADDR_W - WIN_W
) (
   input  logic [ADDR_W-1:0]             cpu_addr,
   input  logic                          cpu_rd,
   input  logic                          cpu_wr,
   input  logic [NUM_WIN-1:0][BANK_W-1:0] win_bank,
   input  logic                          lo_en,
   input  logic                          hi_en,
   output logic [BANK_W+OFF_W-1:0]       ram_addr,
   output logic                          ram_sel,
   output logic                          rom_sel,
   output logic                          rom_hi,
   output logic [OFF_W-1:0]              rom_offset
);

   win_t              win;
   logic [OFF_W-1:0]  off;
   logic              is_read;
   logic              overlay_hit;

   assign win     = cpu_addr[ADDR_W-1 -: WIN_W];
   assign off     = cpu_addr[OFF_W-1:0];
   assign is_read = cpu_rd & ~cpu_wr;

   always_comb begin
      overlay_hit = 1'b0;
      rom_hi      = 1'b0;
      if (win == '0) begin
         overlay_hit = lo_en;
      end else if (win == win_t'(NUM_WIN - 1)) begin
         overlay_hit = hi_en;
         rom_hi      = 1'b1;
      end
   end

   assign ram_addr   = {win_bank[win], off};
   assign rom_sel    = is_read & overlay_hit;
   assign ram_sel    = cpu_wr | (is_read & ~overlay_hit);
   assign rom_offset = off;

endmodule

// File: rtl/bank_overlay_mapper.sv
module bank_overlay_mapper
   import mapper_pkg::*;
#(
   parameter int unsigned ADDR_W       = 16,
   parameter bit          EXPANDED_RAM = 1'b1,
   parameter bit          RST_LO_EN    = 1'b1,
   parameter bit          RST_HI_EN    = 1'b1,
   localparam int unsigned OFF_W       = ADDR_W - WIN_W,
   localparam int unsigned RAM_AW      = BANK_W + OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              map_we,
   input  logic [2:0]        map_code,
   input  logic              rom_we,
   input  logic              lo_rom_en,
   input  logic              hi_rom_en,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_rd,
   input  logic              cpu_wr,
   output logic [RAM_AW-1:0] ram_addr,
   output logic              ram_sel,
   output logic              rom_sel,
   output logic              rom_hi,
   output logic [OFF_W-1:0]  rom_offset
);

   generate
      if (ADDR_W <= WIN_W) begin : g_bad_addr
         $error("ADDR_W must exceed the window select width");
      end
      if (CODE_W != 3 || BANK_W != 3 || NUM_WIN != 4) begin : g_bad_table
         $error("layout table assumes 3-bit codes, 3-bit banks, four windows");
      end
   endgenerate

   map_state_t                     st;
   logic [NUM_WIN-1:0][BANK_W-1:0] win_bank;

   map_state_reg #(
      .EXPANDED_RAM (EXPANDED_RAM),
      .RST_LO_EN    (RST_LO_EN),
      .RST_HI_EN    (RST_HI_EN)
   ) u_state (
      .clk       (clk),
      .rst_n     (rst_n),
      .map_we    (map_we),
      .map_code  (map_code),
      .rom_we    (rom_we),
      .lo_rom_en (lo_rom_en),
      .hi_rom_en (hi_rom_en),
      .state_q   (st)
   );

   bank_table #(
      .EXPANDED_RAM (EXPANDED_RAM)
   ) u_table (
      .code     (st.code),
      .win_bank (win_bank)
   );

   window_decode #(
      .ADDR_W (ADDR_W)
   ) u_dec (
      .cpu_addr   (cpu_addr),
      .cpu_rd     (cpu_rd),
      .cpu_wr     (cpu_wr),
      .win_bank   (win_bank),
      .lo_en      (st.lo_en),
      .hi_en      (st.hi_en),
      .ram_addr   (ram_addr),
      .ram_sel    (ram_sel),
      .rom_sel    (rom_sel),
      .rom_hi     (rom_hi),
      .rom_offset (rom_offset)
   );

endmodule

// File: rtl/mapper_chk.sv
module mapper_chk #(
   parameter int unsigned ADDR_W       = 16,
   parameter bit          EXPANDED_RAM = 1'b1,
   localparam int unsigned OFF_W       = ADDR_W - 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic              cpu_rd,
   input logic              cpu_wr,
   input logic [OFF_W+2:0]  ram_addr,
   input logic              ram_sel,
   input logic              rom_sel,
   input logic [OFF_W-1:0]  rom_offset
);

   logic [1:0] win;
   logic [2:0] bank;
   assign win  = cpu_addr[ADDR_W-1 -: 2];
   assign bank = ram_addr[OFF_W+2 -: 3];

   // R8
   wr_to_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_wr |-> (ram_sel && !rom_sel));

   // R6
   one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ram_sel, rom_sel}));

   // R9
   mid_win_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && (win == 2'd1 || win == 2'd2)) |-> (ram_sel && !rom_sel));

   // R10
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_rd && !cpu_wr) |-> (!ram_sel && !rom_sel));

   // R1
   offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_addr[OFF_W-1:0] == cpu_addr[OFF_W-1:0]) && (rom_offset == cpu_addr[OFF_W-1:0]));

   // R2
   win0_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win == 2'd0) |-> (bank == 3'd0 || bank == 3'd4));

   // R2
   win2_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win == 2'd2) |-> (bank == 3'd2 || bank == 3'd6));

   // R4
   generate
      if (!EXPANDED_RAM) begin : g_fixed
         identity_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bank == {1'b0, win});
      end
   endgenerate

endmodule

bind bank_overlay_mapper mapper_chk #(
   .ADDR_W       (ADDR_W),
   .EXPANDED_RAM (EXPANDED_RAM)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cpu_addr   (cpu_addr),
   .cpu_rd     (cpu_rd),
   .cpu_wr     (cpu_wr),
   .ram_addr   (ram_addr),
   .ram_sel    (ram_sel),
   .rom_sel    (rom_sel),
   .rom_offset (rom_offset)
);

// File: tb/sim_bank_overlay_mapper.sv
module sim_bank_overlay_mapper;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n;
   logic        map_we, rom_we, lo_in, hi_in, rd, wr;
   logic [2:0]  code_in;
   logic [15:0] addr;

   logic [16:0] ram_addr0, ram_addr1;
   logic        ram_sel0, rom_sel0, rom_hi0, ram_sel1, rom_sel1, rom_hi1;
   logic [13:0] rom_off0, rom_off1;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // model state
   logic [2:0] m_code;
   logic       m_lo, m_hi;

   bank_overlay_mapper u0 (
      .clk(clk), .rst_n(rst_n), .map_we(map_we), .map_code(code_in),
      .rom_we(rom_we), .lo_rom_en(lo_in), .hi_rom_en(hi_in),
      .cpu_addr(addr), .cpu_rd(rd), .cpu_wr(wr),
      .ram_addr(ram_addr0), .ram_sel(ram_sel0), .rom_sel(rom_sel0),
      .rom_hi(rom_hi0), .rom_offset(rom_off0));

   bank_overlay_mapper #(.EXPANDED_RAM(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .map_we(map_we), .map_code(code_in),
      .rom_we(rom_we), .lo_rom_en(lo_in), .hi_rom_en(hi_in),
      .cpu_addr(addr), .cpu_rd(rd), .cpu_wr(wr),
      .ram_addr(ram_addr1), .ram_sel(ram_sel1), .rom_sel(rom_sel1),
      .rom_hi(rom_hi1), .rom_offset(rom_off1));

   function automatic logic [2:0] exp_bank(input logic [2:0] c, input logic [1:0] w);
      logic [11:0] row;
      case (c)
         3'd0: row = {3'd0, 3'd1, 3'd2, 3'd3};
         3'd1: row = {3'd0, 3'd1, 3'd2, 3'd7};
         3'd2: row = {3'd4, 3'd5, 3'd6, 3'd7};
         3'd3: row = {3'd0, 3'd3, 3'd2, 3'd7};
         3'd4: row = {3'd0, 3'd4, 3'd2, 3'd3};
         3'd5: row = {3'd0, 3'd5, 3'd2, 3'd3};
         3'd6: row = {3'd0, 3'd6, 3'd2, 3'd3};
         default: row = {3'd0, 3'd7, 3'd2, 3'd3};
      endcase
      return row[(3 - w) * 3 +: 3];
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h (addr %h rd %b wr %b code %0d)",
                  req, act, exp, addr, rd, wr, m_code);
      end
   endtask

   // Check both instances against the model for current inputs.
   task automatic check_outputs(input string req);
      logic [1:0] w;
      logic       rdonly, hit;
      w      = addr[15:14];
      rdonly = rd & ~wr;
      hit    = (w == 2'd0 && m_lo) || (w == 2'd3 && m_hi);
      check({req, " R1/R2 ram_addr"}, 32'(ram_addr0), 32'({exp_bank(m_code, w), addr[13:0]}));
      check({req, " R6/R7/R8/R9/R10 sel"}, 32'({ram_sel0, rom_sel0}),
            32'({wr | (rdonly & ~hit), rdonly & hit}));
      if (rdonly & hit) begin
         check({req, " R6/R7 rom_hi"}, 32'(rom_hi0), 32'(w == 2'd3));
         check({req, " R6/R7 rom_offset"}, 32'(rom_off0), 32'(addr[13:0]));
      end
      check({req, " R4 identity ram_addr"}, 32'(ram_addr1), 32'({1'b0, w, addr[13:0]}));
   endtask

   // One cycle: drive after negedge, check before posedge, update model after.
   task automatic step(input logic mwe, input logic [2:0] c, input logic rwe,
                       input logic l, input logic h, input logic [15:0] a,
                       input logic r, input logic wv, input string req);
      @(negedge clk);
      map_we = mwe; code_in = c; rom_we = rwe; lo_in = l; hi_in = h;
      addr = a; rd = r; wr = wv;
      #1;
      check_outputs(req);   // R5/R11: strobe cycle still shows old state
      @(posedge clk);
      #1;
      if (mwe) m_code = c;
      if (rwe) begin m_lo = l; m_hi = h; end
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      rst_n = 1'b0; map_we = 0; rom_we = 0; code_in = 0; lo_in = 0; hi_in = 0;
      addr = 0; rd = 0; wr = 0;
      m_code = 3'd0; m_lo = 1'b1; m_hi = 1'b1;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R3: reset state, identity map with both overlays enabled
      for (int w = 0; w < 4; w++) begin
         step(0, 0, 0, 0, 0, {w[1:0], 14'h0123}, 1, 0, "R3 reset read");
         step(0, 0, 0, 0, 0, {w[1:0], 14'h2ABC}, 0, 1, "R3 reset write");
      end
      step(0, 0, 0, 0, 0, 16'h0000, 1, 0, "R3 lower rom at reset");
      check("R3 rom_sel lower", 32'(rom_sel0), 32'd1);
      step(0, 0, 0, 0, 0, 16'hFFFF, 1, 0, "R3 upper rom at reset");
      check("R3 rom_sel upper", 32'(rom_sel0), 32'd1);

      // R2/R5: every code, every window, via writes
      for (int c = 0; c < 8; c++) begin
         step(1, c[2:0], 0, 0, 0, 16'h8000, 0, 1, "R5 strobe cycle");
         for (int w = 0; w < 4; w++)
            step(0, 0, 0, 0, 0, {w[1:0], 14'h3FFF}, 0, 1, "R2 table");
      end

      // R11: overlay write keeps layout; overlays off then lower-only
      step(1, 3'd2, 0, 0, 0, 16'h0000, 0, 0, "R10 idle");
      step(0, 0, 1, 0, 0, 16'h0001, 1, 0, "R11 rom strobe");
      step(0, 0, 0, 0, 0, 16'h0001, 1, 0, "R6 lower off");
      check("R6 ram_sel lower off", 32'(ram_sel0), 32'd1);
      step(0, 0, 0, 0, 0, 16'hC001, 1, 0, "R7 upper off");
      check("R11 layout kept bank", 32'(ram_addr0[16:14]), 32'd7);
      step(0, 0, 1, 1, 0, 16'hC002, 1, 0, "R11 rom strobe 2");
      step(0, 0, 0, 0, 0, 16'h0002, 1, 1, "R8 rd+wr slot0");
      step(0, 0, 0, 0, 0, 16'h0003, 1, 0, "R6 lower on");
      step(0, 0, 0, 0, 0, 16'hC003, 1, 0, "R7 upper still off");
      step(0, 0, 0, 0, 0, 16'h5555, 1, 0, "R9 mid window");

      // random traffic
      for (int i = 0; i < 4000; i++) begin
         logic [31:0] rv;
         rv = $urandom;
         step(rv[0] & rv[1], rv[4:2], rv[5] & rv[6], rv[7], rv[8],
              $urandom, rv[9], rv[10] & rv[11], "random");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule